// File: doc/BRIEF.md
# Recursive Pipelined Vector Sum Reducer

This block turns a stream of 64-bit two's complement integers into one sum. It uses a single eight-stage pipelined adder. Each arriving element goes into adder operand A. The adder's own output comes back into operand B, so eight separate running totals travel round the pipeline, one in each stage. The reduction therefore never stalls on the adder latency, and the stream can be taken at one element per clock.

Once the element marked last has been accepted, the eight running totals leave the adder one per cycle. The block then folds them in three passes through a small circular delay buffer:

- Each pass holds the first half of the totals back by half the group size.
- The held values meet the second half at the adder inputs.
- The group sizes are 8 to 4, then 4 to 2, then 2 to 1.

The single value left over is registered as the result, together with a one-cycle done pulse. Input is refused from the last element until that pulse.

Top module: `vsum_reducer`

## Requirements
- R1: During and right after reset, `in_ready` is 1, `res_done` is 0 and `res_data` is 0.
- R2: While a reduction is collecting, an element is taken at each rising edge where `in_valid` and `in_ready` are both 1. Idle cycles between elements are allowed and add nothing.
- R3: After the edge that accepts an element with `in_last` = 1, `in_ready` stays 0 until the cycle in which `res_done` is 1. In that cycle `in_ready` is 1 again.
- R4: `res_data` is the sum modulo 2^64 of all accepted elements of the vector, with two's complement wrap-around.
- R5: Vectors shorter than eight elements, including a single element, give the correct sum. Running totals that never received an element count as zero.
- R6: `res_done` is high for exactly one cycle per reduction. `res_data` changes only in a cycle in which `res_done` is 1.
- R7: Elements presented while `in_ready` is 0 are not accepted and do not change the result.
- R8: For a vector fed without gaps, `res_done` rises 32 clock edges after the edge that accepts the last element when the vector has at least eight elements. For n < 8 elements it rises 40 − n edges after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element present on `in_data` |
| in_data | input | 64 | Element value, two's complement |
| in_last | input | 1 | Marks the final element of the vector |
| in_ready | output | 1 | Block will take an element at this edge |
| res_data | output | 64 | Registered reduction result |
| res_done | output | 1 | One-cycle pulse, result valid |

## Verification
The checker watches four things on every cycle:

- `res_done` never lasts longer than one cycle.
- `res_data` moves only together with `res_done`.
- `in_ready` falls after a last element and stays low for the whole fold.
- `in_ready` returns only with the done pulse.

The sums themselves need the bench's scenarios. These include long, gapped, short and wrapping vectors, and junk presented while busy. The exact latency of the fold and the alignment of the eight running totals can only be seen there as well.

// File: rtl/vsum_pkg.sv
package vsum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_COLL = 2'd2
  } vsum_state_e;
endpackage

// File: rtl/vsum_add_pipe.sv
module vsum_add_pipe #(
  parameter int W      = 64,
  parameter int STAGES = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         vld_o,
  output logic [W-1:0] sum_o
);
  logic [STAGES-1:0] vld_q;
  logic [W-1:0]      dat_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) vld_q[0] <= 1'b0;
    else     vld_q[0] <= vld_i;
    dat_q[0] <= a_i + b_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vld_q[s] <= 1'b0;
      else     vld_q[s] <= vld_q[s-1];
      dat_q[s] <= dat_q[s-1];
    end
  end

  assign vld_o = vld_q[STAGES-1];
  assign sum_o = dat_q[STAGES-1];
endmodule

// File: rtl/vsum_delay_buf.sv
module vsum_delay_buf #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [W-1:0]     wdata,
  input  logic [PTR_W-1:0] rd_dist,
  output logic [W-1:0]     rdata
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (rst)     wr_ptr <= '0;
    else if (we) wr_ptr <= wr_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wdata;
  end

  assign rd_ptr = wr_ptr - rd_dist;
  assign rdata  = mem[rd_ptr];
endmodule

// File: rtl/vsum_reducer.sv
module vsum_reducer #(
  parameter int DATA_W     = 64,
  parameter int ADD_STAGES = 8,
  parameter int BUF_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_done
);
  import vsum_pkg::*;

  localparam int LANES  = ADD_STAGES;
  localparam int STEPS  = $clog2(LANES);
  localparam int STEP_W = $clog2(STEPS + 1) + 1;
  localparam int CNT_W  = $clog2(LANES) + 1;
  localparam int PTR_W  = $clog2(BUF_DEPTH);

  vsum_state_e       state_q;
  logic [CNT_W-1:0]  fill_q;
  logic              last_seen_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  ocnt_q;

  logic              accept;
  logic              feeding;
  logic              end_acc;
  logic [CNT_W-1:0]  half;
  logic [CNT_W-1:0]  step_end;
  logic              add_vld;
  logic [DATA_W-1:0] add_a;
  logic [DATA_W-1:0] add_b;
  logic              sum_vld;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] buf_rd;

  assign in_ready = (state_q == ST_IDLE) || ((state_q == ST_ACC) && !last_seen_q);
  assign accept   = in_valid && in_ready;
  assign feeding  = (state_q == ST_ACC) || ((state_q == ST_IDLE) && accept);
  assign end_acc  = (state_q == ST_ACC) && (last_seen_q || (accept && in_last))
                    && (fill_q == CNT_W'(LANES - 1));

  assign half     = CNT_W'(LANES) >> (step_q + 1'b1);
  assign step_end = (half << 1) - 1'b1;

  always_comb begin
    add_vld = 1'b0;
    add_a   = '0;
    add_b   = '0;
    if (feeding) begin
      add_vld = 1'b1;
      add_a   = accept ? in_data : '0;
      add_b   = sum_vld ? sum : '0;
    end else if ((state_q == ST_COLL) && sum_vld && (step_q < STEP_W'(STEPS))
                 && (ocnt_q >= half)) begin
      add_vld = 1'b1;
      add_a   = buf_rd;
      add_b   = sum;
    end
  end

  vsum_add_pipe #(.W(DATA_W), .STAGES(ADD_STAGES)) u_add (
    .clk   (clk),
    .rst   (rst),
    .vld_i (add_vld),
    .a_i   (add_a),
    .b_i   (add_b),
    .vld_o (sum_vld),
    .sum_o (sum)
  );

  vsum_delay_buf #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .we      (state_q == ST_COLL),
    .wdata   (sum),
    .rd_dist (PTR_W'(half)),
    .rdata   (buf_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      fill_q      <= '0;
      last_seen_q <= 1'b0;
      step_q      <= '0;
      ocnt_q      <= '0;
      res_data    <= '0;
      res_done    <= 1'b0;
    end else begin
      res_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q     <= ST_ACC;
            fill_q      <= CNT_W'(1);
            last_seen_q <= in_last;
          end
        end
        ST_ACC: begin
          if (fill_q != CNT_W'(LANES - 1)) fill_q <= fill_q + 1'b1;
          if (accept && in_last) last_seen_q <= 1'b1;
          if (end_acc) begin
            state_q     <= ST_COLL;
            last_seen_q <= 1'b0;
            step_q      <= '0;
            ocnt_q      <= '0;
          end
        end
        ST_COLL: begin
          if (sum_vld) begin
            if (step_q == STEP_W'(STEPS)) begin
              res_data <= sum;
              res_done <= 1'b1;
              state_q  <= ST_IDLE;
              fill_q   <= '0;
              step_q   <= '0;
            end else if (ocnt_q == step_end) begin
              step_q <= step_q + 1'b1;
              ocnt_q <= '0;
            end else begin
              ocnt_q <= ocnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vsum_reducer_chk.sv
module vsum_reducer_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic              res_done,
  input logic [DATA_W-1:0] res_data,
  input logic              collapsing
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_done |=> !res_done); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_data != $past(res_data)) |-> res_done); // R6

  AST_BUSY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready); // R3

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    res_done |-> in_ready); // R3

  AST_READY_RETURNS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> res_done); // R3

  AST_NO_READY_IN_FOLD: assert property (@(posedge clk) disable iff (rst)
    collapsing |-> !in_ready); // R7
endmodule

bind vsum_reducer vsum_reducer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .in_ready   (in_ready),
  .res_done   (res_done),
  .res_data   (res_data),
  .collapsing (state_q == vsum_pkg::ST_COLL)
);

// File: tb/test_vsum_reducer.sv
module test_vsum_reducer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [63:0] res_data;
  logic        res_done;

  int checks = 0;
  int fails  = 0;
  logic [63:0] vec [0:63];

  always #2 clk = ~clk;

  vsum_reducer i_vsum_reducer (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .res_data (res_data),
    .res_done (res_done)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drives vec[0..n-1]; gap>0 inserts an idle cycle before every gap-th element
  task automatic run_vec(input int n, input int gap, input bit junk, input string sum_tag);
    logic [63:0] exp = '0;
    int lat = 0;
    bit done = 0;
    bit busy_ok = 1;
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) begin
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = vec[i]; in_last = (i == n - 1);
      check(in_ready === 1'b1, "R2 ready while collecting", 64'(in_ready), 64'd1);
      exp += vec[i];
    end
    @(posedge clk);
    while (!done && lat < 400) begin
      @(negedge clk);
      if (res_done === 1'b1) begin
        in_valid = 1'b0; in_last = 1'b0;
        done = 1;
      end else begin
        if (in_ready !== 1'b0) busy_ok = 0;
        in_valid = junk; in_last = junk; in_data = 64'h7777_0000_1234_5678;
        @(posedge clk);
        lat++;
      end
    end
    check(busy_ok, "R3 ready low while busy", 64'(busy_ok), 64'd1);
    check(done, "R6 done seen", 64'(done), 64'd1);
    check(res_data === exp, sum_tag, res_data, exp);
    check(in_ready === 1'b1, "R3 ready back at done", 64'(in_ready), 64'd1);
    if (gap == 0)
      check(lat == ((n >= 8) ? 32 : 40 - n), "R8 latency", 64'(lat), 64'((n >= 8) ? 32 : 40 - n));
    @(negedge clk);
    check(res_done === 1'b0, "R6 done single cycle", 64'(res_done), 64'd0);
    check(res_data === exp, "R6 result held", res_data, exp);
  endtask

  task automatic t_reset();
    check(in_ready === 1'b1, "R1 ready in reset", 64'(in_ready), 64'd1);
    check(res_done === 1'b0, "R1 done low", 64'(res_done), 64'd0);
    check(res_data === 64'd0, "R1 result zero", res_data, 64'd0);
  endtask

  task automatic t_long();
    for (int i = 0; i < 20; i++) vec[i] = 64'(i + 1);
    run_vec(20, 0, 1'b0, "R4 long sum");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 13; i++) vec[i] = 64'(i) * 64'h0123_4567_89AB_CDEF;
    run_vec(13, 3, 1'b0, "R2 gapped sum");
  endtask

  task automatic t_short();
    vec[0] = 64'd42;
    run_vec(1, 0, 1'b0, "R5 single element");
    vec[0] = 64'd5; vec[1] = -64'd9; vec[2] = 64'd100;
    run_vec(3, 0, 1'b0, "R5 three elements");
    for (int i = 0; i < 7; i++) vec[i] = 64'(1) << (i * 8);
    run_vec(7, 0, 1'b0, "R5 seven elements");
    for (int i = 0; i < 8; i++) vec[i] = 64'(1) << (i * 7);
    run_vec(8, 0, 1'b0, "R5 eight elements");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 10; i++)
      vec[i] = (i % 2 == 0) ? 64'hFFFF_FFFF_FFFF_FFF0 - 64'(i) : 64'h8000_0000_0000_0001;
    run_vec(10, 0, 1'b0, "R4 wrap-around sum");
  endtask

  task automatic t_refuse();
    for (int i = 0; i < 9; i++) vec[i] = 64'(3 * i + 11);
    run_vec(9, 0, 1'b1, "R7 junk while busy ignored");
    for (int i = 0; i < 4; i++) vec[i] = 64'(i + 1000);
    run_vec(4, 0, 1'b1, "R7 junk while filling ignored");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_long();
    t_gaps();
    t_short();
    t_wrap();
    t_refuse();
    t_long();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule